// File: doc/BRIEF.md
# Two-Stage Converter Clock Prescaler

This block derives a slow converter clock from the system clock. A first stage counts system clock cycles modulo a ratio chosen by a 5-bit field. A second stage toggles on each wrap of the first, so the output is a square wave with half the first stage's rate. The field value 0 gives a first-stage divide of 2, and values 1 to 31 give a divide of the value plus one. The total divide from system clock to converter clock is therefore 4 to 64.

The output is meant to be used as a clock enable, not as a gated clock. A one-system-cycle tick marks each cycle in which the converter clock goes high. The block keeps a copy of the ratio field. Whenever the field differs from that copy, both stages restart from a clean phase. Dropping the enable holds both stages cleared.

Top module: `presc_two_stage`

## Requirements
- R1: While rst is high at a clock edge, conv_clk and conv_tick are 0 after that edge.
- R2: For ratio values 1 to 31, held steady with en high, conv_clk has a period of 2*(ratio+1) system clock cycles.
- R3: A ratio value of 0 behaves as a first-stage divide of 2, so conv_clk has a period of 4 system cycles, the same as ratio 1.
- R4: A ratio value of 31 gives the largest total divide: conv_clk has a period of 64 system cycles.
- R5: conv_clk is a square wave. With d the first-stage divide, it stays high for d cycles and low for d cycles.
- R6: conv_tick is high for exactly one cycle, in the first cycle that conv_clk is high, and at no other time.
- R7: At any clock edge where the ratio input differs from its value at the previous edge, conv_clk and conv_tick become 0. Counting restarts, and conv_clk next rises d edges later.
- R8: While en is low at a clock edge, both stages are cleared and conv_clk and conv_tick are 0.
- R9: After reset is released, or after en is raised, with a steady ratio, the first rise of conv_clk comes after d clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable. When low, both stages are held cleared |
| ratio | input | 5 | First-stage ratio field. Value 0 divides by 2, value n divides by n+1 |
| conv_clk | output | 1 | Divided square output, used as a clock enable |
| conv_tick | output | 1 | One-cycle pulse in the first high cycle of conv_clk |

## Verification
The case that is hardest to reach from the ports is a ratio change that lands exactly on the cycle in which the first stage wraps, or in the cycle of a tick. In that case the restart must take priority over the toggle. The stimulus changes the ratio at several offsets inside a running period, including the wrap cycle of a short ratio. It also drops en in the middle of a high phase. A behavioural phase-count model is compared with both outputs on every cycle.

// File: rtl/presc_two_stage.sv
module presc_two_stage #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] ratio,
  output logic         conv_clk,
  output logic         conv_tick
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt, ratio_q, last;
  logic wrap, clean;

  assign last  = (ratio_q == '0) ? ONE : ratio_q;
  assign wrap  = (cnt == last);
  assign clean = rst | ~en | (ratio != ratio_q);

  always_ff @(posedge clk) begin
    ratio_q <= ratio;
    if (clean) begin
      cnt       <= '0;
      conv_clk  <= 1'b0;
      conv_tick <= 1'b0;
    end else begin
      cnt       <= wrap ? '0 : cnt + ONE;
      conv_clk  <= conv_clk ^ wrap;
      conv_tick <= wrap & ~conv_clk;
    end
  end
endmodule

module presc_two_stage_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] ratio,
  input logic         conv_clk,
  input logic         conv_tick
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!conv_clk && !conv_tick));
  // R6
  tick_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    conv_tick |-> (conv_clk && !$past(conv_clk)));
  // R6
  tick_single_chk: assert property (@(posedge clk) disable iff (rst) conv_tick |=> !conv_tick);
  // R6
  rise_has_tick_chk: assert property (@(posedge clk) disable iff (rst) $rose(conv_clk) |-> conv_tick);
  // R8
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst) !en |=> (!conv_clk && !conv_tick));
  // R7
  ratio_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio != $past(ratio)) |=> (!conv_clk && !conv_tick));
endmodule

bind presc_two_stage presc_two_stage_chk #(.W(W)) chk (
  .clk(clk), .rst(rst), .en(en), .ratio(ratio),
  .conv_clk(conv_clk), .conv_tick(conv_tick)
);

// File: tb/tb_presc_two_stage.sv
module tb_presc_two_stage;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [4:0] ratio = 5'd0;
  logic conv_clk, conv_tick;

  int tests = 0, fails = 0, cycles = 0;
  int p = 0, d = 2, mr = 0;
  bit started = 0, done = 0;
  string req = "R1";

  presc_two_stage dut (.clk(clk), .rst(rst), .en(en), .ratio(ratio),
                       .conv_clk(conv_clk), .conv_tick(conv_tick));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst || !en || int'(ratio) != mr) p = 0;
    else p = p + 1;
    mr = int'(ratio);
    d = (mr == 0) ? 2 : mr + 1;
    started = 1;
    cycles++;
  end

  always @(negedge clk) if (started && !done) begin
    automatic bit ec = ((p / d) % 2) == 1;
    automatic bit et = (p > 0) && ((p % (2 * d)) == d);
    tests++;
    if (conv_clk !== ec || conv_tick !== et) begin
      fails++;
      $display("FAIL %s cycle %0d: clk/tick actual %b%b expected %b%b",
               req, cycles, conv_clk, conv_tick, ec, et);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic period_check(int exp, string tag);
    int t0, t1;
    @(posedge conv_tick); t0 = cycles;
    @(posedge conv_tick); t1 = cycles;
    tests++;
    if (t1 - t0 != exp) begin
      fails++;
      $display("FAIL %s period actual %0d expected %0d", tag, t1 - t0, exp);
    end
  endtask

  initial begin
    fork
      begin
        req = "R1"; run(3);
        en = 1; run(2);
        req = "R9"; ratio = 5'd3; @(negedge clk); rst = 0; run(20);
        req = "R2"; period_check(8, "R2");
        ratio = 5'd5; run(30); period_check(12, "R2");
        req = "R3"; ratio = 5'd0; run(10); period_check(4, "R3");
        ratio = 5'd1; run(10); period_check(4, "R3");
        req = "R4"; ratio = 5'd31; run(70); period_check(64, "R4");
        req = "R5"; ratio = 5'd17; run(80);
        req = "R7"; ratio = 5'd1; run(1); ratio = 5'd2; run(7);
        ratio = 5'd4; run(4); ratio = 5'd6; run(9); ratio = 5'd3; run(20);
        req = "R8"; ratio = 5'd9; run(15); en = 0; run(5);
        req = "R9"; en = 1; run(40);
        req = "R1"; rst = 1; run(3); rst = 0; run(20);
        done = 1;
      end
      begin
        run(20000);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule